// File: doc/BRIEF.md
# Zero-Fill Barrel Shifter

This block shifts a 32-bit operand left or right by any amount from 0 to 31 in one pass, filling the vacated positions with zeros. The shift is done by rotation: the operand is widened to 64 bits with zeros above it, and the widened word goes through three rotate-right levels of 4-way multiplexers. The first level steps in sixteens, the second in fours and the third in ones. The low 32 bits of the last level are the result. A left shift is a right rotation by 64 minus the amount. The upper zeros then come round into the low positions as the fill.

Each level is trimmed to the bits that later levels can still reach: 47 bits after the coarse level and 35 after the medium one. The network is purely combinational. Its result is captured in one output register, so a result appears on the clock edge after the operands were sampled.

Top module: `zfs_shifter`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0 on the next clock edge, whatever the other inputs are.
- R2: `result_o` is the shift of the operand, amount and direction sampled on the previous rising clock edge. Changing the inputs between edges does not change `result_o`.
- R3: With `shift_left_i` = 0, `result_o` is `operand_i` moved right by `amount_i` positions, with zeros entering at bit 31.
- R4: With `shift_left_i` = 1, `result_o` is `operand_i` moved left by `amount_i` positions, with zeros entering at bit 0.
- R5: An amount of 0 returns the operand unchanged in both directions. A left shift by 0 is not treated as a rotation by 64.
- R6: An amount of 31 keeps only bit 0 of the operand (moved to bit 31) for a left shift, and only bit 31 (moved to bit 0) for a right shift. All other result bits are 0.
- R7: The result never has more set bits than the operand it came from.
- R8: R3 and R4 hold for all 64 pairs of direction and amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Active-low reset; clears the result register |
| operand_i | input | 32 | Word to be shifted |
| amount_i | input | 5 | Shift distance, 0 to 31 |
| shift_left_i | input | 1 | 1 selects a left shift, 0 selects a right shift |
| result_o | output | 32 | Registered shifted word |

## Verification
A wrong select field shows up as a result moved by a multiple of 16, 4 or 1 positions away from the right place. It appears on the clock edge after the operand is applied. A wrong negation of the amount corrupts left shifts and leaves right shifts intact. Left shifts by 0 and by 31 expose an off-by-one or a missed wrap to zero at once. A trimming error in a level leaves only the high result bits wrong, so the bench compares every bit of every result against a bit-by-bit model on each clock. It also sweeps every amount in both directions.

// File: rtl/zfs_pkg.sv
package zfs_pkg;
    localparam int DATA_W  = 32;
    localparam int SHAMT_W = 5;
    localparam int SEL_W   = 2;
    localparam int LEVELS  = 3;
    localparam int ROT_W   = SEL_W * LEVELS;
    localparam int WIDE_W  = 2 * DATA_W;
    localparam int STEP_FINE   = 1;
    localparam int STEP_MID    = STEP_FINE << SEL_W;
    localparam int STEP_COARSE = STEP_MID << SEL_W;
    localparam int FAN   = (1 << SEL_W) - 1;
    localparam int W_FINE_IN = DATA_W + FAN * STEP_FINE;
    localparam int W_MID_IN  = W_FINE_IN + FAN * STEP_MID;

    typedef struct packed {
        logic [DATA_W-1:0] result;
    } zfs_state_t;
endpackage

// File: rtl/zfs_amount.sv
module zfs_amount #(
    parameter int SHAMT_W = 5,
    parameter int ROT_W   = 6
) (
    input  logic [SHAMT_W-1:0] amount_i,
    input  logic               left_i,
    output logic [ROT_W-1:0]   rot_o
);
    localparam logic [ROT_W-1:0] ONE = ROT_W'(1);
    logic [ROT_W-1:0] ext;

    always_comb begin
        ext   = {{(ROT_W-SHAMT_W){1'b0}}, amount_i};
        rot_o = left_i ? (~ext + ONE) : ext;
    end
endmodule

// File: rtl/zfs_level.sv
module zfs_level #(
    parameter int IN_W  = 64,
    parameter int OUT_W = 47,
    parameter int STEP  = 16
) (
    input  logic [IN_W-1:0]  din,
    input  logic [1:0]       sel,
    output logic [OUT_W-1:0] dout
);
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        localparam int IX0 = i % IN_W;
        localparam int IX1 = (i + STEP) % IN_W;
        localparam int IX2 = (i + 2 * STEP) % IN_W;
        localparam int IX3 = (i + 3 * STEP) % IN_W;
        assign dout[i] = sel[1] ? (sel[0] ? din[IX3] : din[IX2])
                                : (sel[0] ? din[IX1] : din[IX0]);
    end
endmodule

// File: rtl/zfs_shifter.sv
module zfs_shifter
    import zfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  operand_i,
    input  logic [SHAMT_W-1:0] amount_i,
    input  logic               shift_left_i,
    output logic [DATA_W-1:0]  result_o
);
    logic [ROT_W-1:0]     rot;
    logic [WIDE_W-1:0]    wide;
    logic [W_MID_IN-1:0]  lvl_coarse;
    logic [W_FINE_IN-1:0] lvl_mid;
    logic [DATA_W-1:0]    lvl_fine;
    zfs_state_t st_d, st_q;

    assign wide = {{DATA_W{1'b0}}, operand_i};

    zfs_amount #(.SHAMT_W(SHAMT_W), .ROT_W(ROT_W)) u_amount (
        .amount_i (amount_i),
        .left_i   (shift_left_i),
        .rot_o    (rot)
    );

    zfs_level #(.IN_W(WIDE_W), .OUT_W(W_MID_IN), .STEP(STEP_COARSE)) u_coarse (
        .din  (wide),
        .sel  (rot[5:4]),
        .dout (lvl_coarse)
    );

    zfs_level #(.IN_W(W_MID_IN), .OUT_W(W_FINE_IN), .STEP(STEP_MID)) u_mid (
        .din  (lvl_coarse),
        .sel  (rot[3:2]),
        .dout (lvl_mid)
    );

    zfs_level #(.IN_W(W_FINE_IN), .OUT_W(DATA_W), .STEP(STEP_FINE)) u_fine (
        .din  (lvl_mid),
        .sel  (rot[1:0]),
        .dout (lvl_fine)
    );

    always_comb begin
        st_d        = st_q;
        st_d.result = lvl_fine;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
endmodule

// File: rtl/zfs_shifter_chk.sv
module zfs_shifter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] operand_i,
    input logic [4:0]  amount_i,
    input logic        shift_left_i,
    input logic [31:0] result_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R3
    right_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(shift_left_i) |-> result_o == ($past(operand_i) >> $past(amount_i)));

    // R4
    left_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(shift_left_i) |-> result_o == ($past(operand_i) << $past(amount_i)));

    // R5
    zero_amount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(amount_i) == 5'd0 |-> result_o == $past(operand_i));

    // R6
    left_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(shift_left_i) && $past(amount_i) == 5'd31 |-> result_o[30:0] == 31'd0);

    // R7
    no_new_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> $countones(result_o) <= $countones($past(operand_i)));
endmodule

bind zfs_shifter zfs_shifter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .operand_i    (operand_i),
    .amount_i     (amount_i),
    .shift_left_i (shift_left_i),
    .result_o     (result_o)
);

// File: tb/zfs_shifter_test.sv
module zfs_shifter_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand_i = '0;
    logic [4:0]  amount_i = '0;
    logic        shift_left_i = 1'b0;
    logic [31:0] result_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    logic [31:0] opd_q[$];
    string       tag_q[$];

    zfs_shifter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .operand_i    (operand_i),
        .amount_i     (amount_i),
        .shift_left_i (shift_left_i),
        .result_o     (result_o)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_shift(logic [31:0] a, int s, logic l);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            int src = l ? i - s : i + s;
            if (src >= 0 && src < 32) r[i] = a[src];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: result=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pop_check();
        logic [31:0] e = exp_q.pop_front();
        logic [31:0] o = opd_q.pop_front();
        string t = tag_q.pop_front();
        check(t, result_o, e);
        checks++;
        if ($countones(result_o) > $countones(o)) begin
            fails++;
            $display("FAIL R7: popcount=%0d expected<=%0d", $countones(result_o), $countones(o));
        end
    endtask

    task automatic step(logic [31:0] a, logic [4:0] s, logic l, string tag);
        string t = tag;
        @(negedge clk);
        if (t == "") t = (s == 0) ? "R5" : (s == 31) ? "R6" : (l ? "R4" : "R3");
        if (exp_q.size() > 0) begin
            logic [31:0] held = exp_q[0];
            pop_check();
            operand_i = a; amount_i = s; shift_left_i = l;
            #1;
            check("R2", result_o, held);
        end else begin
            operand_i = a; amount_i = s; shift_left_i = l;
        end
        exp_q.push_back(ref_shift(a, int'(s), l));
        opd_q.push_back(a);
        tag_q.push_back(t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: result=%h expected=completion", result_o);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        operand_i = 32'hDEAD_BEEF; amount_i = 5'd7; shift_left_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", result_o, 32'h0);
        @(negedge clk);
        operand_i = 32'h1234_5678;
        @(negedge clk);
        check("R1", result_o, 32'h0);
        rst_n = 1'b1;

        step(32'hF0F0_1234, 5'd0,  1'b0, "");
        step(32'hF0F0_1234, 5'd0,  1'b1, "");
        step(32'h8000_0001, 5'd31, 1'b1, "");
        step(32'h8000_0001, 5'd31, 1'b0, "");
        step(32'hFFFF_FFFF, 5'd31, 1'b1, "");
        step(32'hFFFF_FFFF, 5'd31, 1'b0, "");
        step(32'hA5A5_A5A5, 5'd1,  1'b0, "R3");
        step(32'hA5A5_A5A5, 5'd1,  1'b1, "R4");
        step(32'h0001_8000, 5'd16, 1'b1, "R4");
        step(32'h0001_8000, 5'd16, 1'b0, "R3");
        step(32'h1357_9BDF, 5'd13, 1'b1, "R4");
        step(32'h1357_9BDF, 5'd19, 1'b0, "R3");

        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 32; s++) begin
                step(32'hFFFF_FFFF, 5'(s), d[0], "R8");
                step($urandom, 5'(s), d[0], "R8");
            end
        end

        for (int k = 0; k < 400; k++) begin
            step($urandom, 5'($urandom), 1'($urandom), "");
        end

        @(negedge clk);
        while (exp_q.size() > 0) pop_check();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule